// File: doc/BRIEF.md
# Timer-compare soft interrupt unit

This block sits beside a processor core's privileged register file. It keeps two 64-bit counters: a core tick counter and a system tick counter. It also holds three compare registers. The first is matched against the tick counter. The other two, one ordinary and one hypervisor, are matched against the system tick counter. When a counter reaches an armed compare value, the block sets a fixed bit in a soft-interrupt register or a hypervisor pending register, and raises the matching interrupt request.

Software reaches every register through one write/read port selected by a 4-bit index. The soft-interrupt register can be written three ways: directly, through a set alias that ORs bits in, and through a clear alias that masks bits out. Some writes can make a blocked interrupt deliverable: enabling interrupts, lowering the interrupt level, or touching a queue pointer. These writes produce a one-cycle recheck pulse, so the core re-evaluates its interrupt state. A write to the read-only version register is reported as an illegal access.

Top module: `tick_cmp_irq_unit`

## Requirements
- R1: The register index map is: 0 tick counter, 1 tick compare, 2 system tick counter, 3 system compare, 4 hypervisor compare, 5 soft-interrupt, 6 soft-interrupt set alias, 7 soft-interrupt clear alias, 8 hypervisor pending (bit 0), 9 processor state (interrupt enable at bit 1), 10 interrupt level (4 bits), 11 version, 12 to 15 queue head/tail pointers. `rd_data` shows the selected register combinationally. Indices 6, 7 and 12 to 15 read as 0.
- R2: After reset, each compare register reads 0x8000_0000_0000_0000 (disabled). Every other register reads 0, and all outputs are low.
- R3: Each counter advances by one on every clock edge with `count_en` high, and holds when `count_en` is low. A write to a counter loads the written value, and a write takes priority over the increment.
- R4: Writing V to the set alias makes the soft-interrupt register (old OR V). `soft_irq` is high whenever any soft-interrupt bit is set.
- R5: Writing V to the clear alias makes the soft-interrupt register (old AND NOT V).
- R6: A direct write replaces the whole soft-interrupt value. If a compare match lands on the same edge, its bit is ORed into the written value.
- R7: A tick match sets soft-interrupt bit 0. A tick match occurs on a `count_en` edge where compare bit 63 is 0 and the tick counter equals compare bits 62:0. It fires once per pass of the counter.
- R8: A system compare match (same rule, against the system tick counter) sets soft-interrupt bit 16.
- R9: A hypervisor compare match against the system tick counter sets hypervisor pending bit 0 and raises `hyp_irq`.
- R10: Bit 63 set in a compare register suppresses its match. Setting it while a match is still ahead cancels that match.
- R11: `recheck` pulses for one cycle after any of these writes: a processor-state write that turns the enable bit from 0 to 1; an interrupt-level write below the current level; any queue pointer write. Other writes leave it low.
- R12: The version register reads the `VERSION` parameter and ignores writes. A write to it raises `illegal_wr` for the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| count_en | input | 1 | Counter advance enable |
| wr_en | input | 1 | Register write strobe |
| reg_idx | input | 4 | Register index for read and write |
| wr_data | input | 64 | Write data |
| rd_data | output | 64 | Read data of the indexed register |
| soft_irq | output | 1 | Soft-interrupt request (any bit set) |
| hyp_irq | output | 1 | Hypervisor match request |
| recheck | output | 1 | One-cycle interrupt re-evaluation pulse |
| illegal_wr | output | 1 | Write to read-only version register seen |

## Verification
The hardest case to reach is a compare match landing on the same edge as a direct soft-interrupt write. With 64-bit counters, this cannot happen by waiting for the counter to arrive. The bench first loads the counter with `count_en` low so that it already equals the compare value. It then raises `count_en` and the direct write in the same cycle. The bench also arms a compare, counts part of the way toward it, and then disarms it. This shows that the approaching match never fires.

// File: rtl/tcu_pkg.sv
package tcu_pkg;
  localparam int DATA_W = 64;
  localparam int IDX_W  = 4;
  localparam int PSTATE_IE_BIT = 1;

  typedef enum logic [IDX_W-1:0] {
    IX_TICK      = 4'd0,
    IX_TICK_CMP  = 4'd1,
    IX_STICK     = 4'd2,
    IX_STICK_CMP = 4'd3,
    IX_HCMP      = 4'd4,
    IX_SOFT      = 4'd5,
    IX_SOFT_SET  = 4'd6,
    IX_SOFT_CLR  = 4'd7,
    IX_HPEND     = 4'd8,
    IX_PSTATE    = 4'd9,
    IX_PIL       = 4'd10,
    IX_VER       = 4'd11,
    IX_Q0        = 4'd12,
    IX_Q1        = 4'd13,
    IX_Q2        = 4'd14,
    IX_Q3        = 4'd15
  } reg_idx_e;

  typedef enum logic [1:0] {
    SOP_NONE, SOP_DIRECT, SOP_SET, SOP_CLR
  } soft_op_e;

  // top bit of a compare word is an active-low arm flag
  function automatic logic cmp_armed(input logic [DATA_W-1:0] c);
    return ~c[DATA_W-1];
  endfunction

  function automatic logic [DATA_W-1:0] cmp_target(input logic [DATA_W-1:0] c);
    return {1'b0, c[DATA_W-2:0]};
  endfunction

  function automatic logic [DATA_W-1:0] cmp_reset_val();
    return {1'b1, {(DATA_W-1){1'b0}}};
  endfunction

  function automatic logic is_queue_idx(input logic [IDX_W-1:0] ix);
    return ix >= IX_Q0;
  endfunction
endpackage

// File: rtl/tcu_counter.sv
module tcu_counter #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)   q <= '0;
    else if (ld)  q <= ld_val;
    else if (inc) q <= q + W'(1);
  end
endmodule

// File: rtl/tcu_compare.sv
module tcu_compare
  import tcu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [DATA_W-1:0] wr_val,
  input  logic [DATA_W-1:0] cnt,
  input  logic              step,
  output logic [DATA_W-1:0] cmp_q,
  output logic              hit
);
  always_ff @(posedge clk) begin
    if (!rst_n)  cmp_q <= cmp_reset_val();
    else if (wr) cmp_q <= wr_val;
  end

  // a match exists only on a counting edge, so each pass yields one hit
  assign hit = step && cmp_armed(cmp_q) && (cnt == cmp_target(cmp_q));
endmodule

// File: rtl/tcu_softint.sv
module tcu_softint
  import tcu_pkg::*;
#(
  parameter int W = 17
) (
  input  logic         clk,
  input  logic         rst_n,
  input  soft_op_e     op,
  input  logic [W-1:0] wd,
  input  logic [W-1:0] hits,
  output logic [W-1:0] q
);
  logic [W-1:0] base;

  always_comb begin
    unique case (op)
      SOP_DIRECT: base = wd;
      SOP_SET:    base = q | wd;
      SOP_CLR:    base = q & ~wd;
      default:    base = q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= base | hits;
  end
endmodule

// File: rtl/tick_cmp_irq_unit.sv
module tick_cmp_irq_unit
  import tcu_pkg::*;
#(
  parameter int          SOFT_W      = 17,
  parameter int          TICK_BIT    = 0,
  parameter int          STICK_BIT   = 16,
  parameter int          PSTATE_W    = 8,
  parameter int          PIL_W       = 4,
  parameter logic [63:0] VERSION     = 64'h0000_0017_0003_0200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              count_en,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  reg_idx,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              soft_irq,
  output logic              hyp_irq,
  output logic              recheck,
  output logic              illegal_wr
);
  localparam int N_CMP = 3;

  reg_idx_e idx;
  assign idx = reg_idx_e'(reg_idx);

  // counters
  logic [DATA_W-1:0] tick_q, stick_q;

  tcu_counter #(.W(DATA_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .inc(count_en),
    .ld(wr_en && idx == IX_TICK), .ld_val(wr_data), .q(tick_q)
  );
  tcu_counter #(.W(DATA_W)) u_stick (
    .clk(clk), .rst_n(rst_n), .inc(count_en),
    .ld(wr_en && idx == IX_STICK), .ld_val(wr_data), .q(stick_q)
  );

  // compare bank: slot 0 watches tick, slots 1 and 2 watch system tick
  logic [DATA_W-1:0] cmp_q [N_CMP];
  logic [N_CMP-1:0]  cmp_hit;

  for (genvar i = 0; i < N_CMP; i++) begin : g_cmp
    localparam reg_idx_e SLOT_IDX = (i == 0) ? IX_TICK_CMP :
                                    (i == 1) ? IX_STICK_CMP : IX_HCMP;
    tcu_compare u_cmp (
      .clk(clk), .rst_n(rst_n),
      .wr(wr_en && idx == SLOT_IDX), .wr_val(wr_data),
      .cnt((i == 0) ? tick_q : stick_q), .step(count_en),
      .cmp_q(cmp_q[i]), .hit(cmp_hit[i])
    );
  end

  logic tick_hit, stick_hit, hcmp_hit;
  assign tick_hit  = cmp_hit[0];
  assign stick_hit = cmp_hit[1];
  assign hcmp_hit  = cmp_hit[2];

  // soft-interrupt register
  soft_op_e     soft_op;
  logic [SOFT_W-1:0] soft_hits, softint_q;

  always_comb begin
    soft_op = SOP_NONE;
    if (wr_en) begin
      unique case (idx)
        IX_SOFT:     soft_op = SOP_DIRECT;
        IX_SOFT_SET: soft_op = SOP_SET;
        IX_SOFT_CLR: soft_op = SOP_CLR;
        default:     soft_op = SOP_NONE;
      endcase
    end
    soft_hits = '0;
    soft_hits[TICK_BIT]  = tick_hit;
    soft_hits[STICK_BIT] = stick_hit;
  end

  tcu_softint #(.W(SOFT_W)) u_soft (
    .clk(clk), .rst_n(rst_n), .op(soft_op),
    .wd(wr_data[SOFT_W-1:0]), .hits(soft_hits), .q(softint_q)
  );

  // hypervisor pending, processor state, interrupt level
  logic                hint_q;
  logic [PSTATE_W-1:0] pstate_q;
  logic [PIL_W-1:0]    pil_q;
  logic                ie_rise, pil_drop, q_touch, recheck_d, illegal_d;

  assign ie_rise  = wr_en && idx == IX_PSTATE &&
                    wr_data[PSTATE_IE_BIT] && !pstate_q[PSTATE_IE_BIT];
  assign pil_drop = wr_en && idx == IX_PIL && (wr_data[PIL_W-1:0] < pil_q);
  assign q_touch  = wr_en && is_queue_idx(reg_idx);
  assign recheck_d = ie_rise || pil_drop || q_touch;
  assign illegal_d = wr_en && idx == IX_VER;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hint_q     <= 1'b0;
      pstate_q   <= '0;
      pil_q      <= '0;
      recheck    <= 1'b0;
      illegal_wr <= 1'b0;
    end else begin
      if (hcmp_hit)                     hint_q <= 1'b1;
      else if (wr_en && idx == IX_HPEND) hint_q <= wr_data[0];
      if (wr_en && idx == IX_PSTATE) pstate_q <= wr_data[PSTATE_W-1:0];
      if (wr_en && idx == IX_PIL)    pil_q    <= wr_data[PIL_W-1:0];
      recheck    <= recheck_d;
      illegal_wr <= illegal_d;
    end
  end

  assign soft_irq = |softint_q;
  assign hyp_irq  = hint_q;

  // read mux
  always_comb begin
    rd_data = '0;
    unique case (idx)
      IX_TICK:      rd_data = tick_q;
      IX_TICK_CMP:  rd_data = cmp_q[0];
      IX_STICK:     rd_data = stick_q;
      IX_STICK_CMP: rd_data = cmp_q[1];
      IX_HCMP:      rd_data = cmp_q[2];
      IX_SOFT:      rd_data = {{(DATA_W-SOFT_W){1'b0}}, softint_q};
      IX_HPEND:     rd_data = {{(DATA_W-1){1'b0}}, hint_q};
      IX_PSTATE:    rd_data = {{(DATA_W-PSTATE_W){1'b0}}, pstate_q};
      IX_PIL:       rd_data = {{(DATA_W-PIL_W){1'b0}}, pil_q};
      IX_VER:       rd_data = VERSION;
      default:      rd_data = '0;
    endcase
  end
endmodule

// File: rtl/tcu_checker.sv
module tcu_checker
  import tcu_pkg::*;
#(
  parameter int SOFT_W    = 17,
  parameter int TICK_BIT  = 0,
  parameter int STICK_BIT = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              count_en,
  input logic              wr_en,
  input logic [IDX_W-1:0]  reg_idx,
  input logic [DATA_W-1:0] wr_data,
  input logic [DATA_W-1:0] tick_q,
  input logic [SOFT_W-1:0] softint_q,
  input logic              hint_q,
  input logic              tick_hit,
  input logic              stick_hit,
  input logic              hcmp_hit,
  input logic              recheck,
  input logic              illegal_wr
);
  assert_tick_advance_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (count_en && !(wr_en && reg_idx == IX_TICK)) |=> tick_q == $past(tick_q) + 64'd1);

  assert_set_alias_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_idx == IX_SOFT_SET) |=>
      ((softint_q & $past(wr_data[SOFT_W-1:0])) == $past(wr_data[SOFT_W-1:0])));

  assert_clr_alias_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_idx == IX_SOFT_CLR && !tick_hit && !stick_hit) |=>
      ((softint_q & $past(wr_data[SOFT_W-1:0])) == '0));

  assert_tick_hit_bit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tick_hit |=> softint_q[TICK_BIT]);

  assert_stick_hit_bit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stick_hit |=> softint_q[STICK_BIT]);

  assert_hyp_pending_R9: assert property (@(posedge clk) disable iff (!rst_n)
    hcmp_hit |=> hint_q);

  assert_queue_recheck_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_idx >= IX_Q0) |=> recheck);

  assert_version_illegal_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_idx == IX_VER) |=> illegal_wr);
endmodule

bind tick_cmp_irq_unit tcu_checker #(
  .SOFT_W(SOFT_W), .TICK_BIT(TICK_BIT), .STICK_BIT(STICK_BIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .count_en(count_en), .wr_en(wr_en),
  .reg_idx(reg_idx), .wr_data(wr_data), .tick_q(tick_q),
  .softint_q(softint_q), .hint_q(hint_q), .tick_hit(tick_hit),
  .stick_hit(stick_hit), .hcmp_hit(hcmp_hit), .recheck(recheck),
  .illegal_wr(illegal_wr)
);

// File: tb/tick_cmp_irq_unit_bench.sv
module tick_cmp_irq_unit_bench;
  localparam int          CLK_PERIOD = 10;
  localparam logic [63:0] VER        = 64'h0000_0017_0003_0200;
  localparam logic [63:0] DIS        = 64'h8000_0000_0000_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        count_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  reg_idx = 4'd0;
  logic [63:0] wr_data = '0;
  logic [63:0] rd_data;
  logic        soft_irq, hyp_irq, recheck, illegal_wr;

  int n_tests = 0;
  int n_fail  = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tick_cmp_irq_unit #(.VERSION(VER)) u_tick_cmp_irq_unit (
    .clk(clk), .rst_n(rst_n), .count_en(count_en), .wr_en(wr_en),
    .reg_idx(reg_idx), .wr_data(wr_data), .rd_data(rd_data),
    .soft_irq(soft_irq), .hyp_irq(hyp_irq), .recheck(recheck),
    .illegal_wr(illegal_wr)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] ix, input logic [63:0] d);
    @(negedge clk);
    wr_en = 1'b1; reg_idx = ix; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] ix, output logic [63:0] d);
    reg_idx = ix;
    #1;
    d = rd_data;
  endtask

  task automatic run(input int n);
    @(negedge clk);
    count_en = 1'b1;
    repeat (n) @(negedge clk);
    count_en = 1'b0;
  endtask

  task automatic t_reset();
    logic [63:0] v;
    rd(4'd1, v);  check("R2 tick cmp reset", v, DIS);
    rd(4'd3, v);  check("R2 sys cmp reset", v, DIS);
    rd(4'd4, v);  check("R2 hyp cmp reset", v, DIS);
    rd(4'd0, v);  check("R2 tick reset", v, 64'd0);
    rd(4'd5, v);  check("R2 softint reset", v, 64'd0);
    check("R2 outputs reset", {60'd0, soft_irq, hyp_irq, recheck, illegal_wr}, 64'd0);
  endtask

  task automatic t_counters();
    logic [63:0] v;
    wr(4'd0, 64'd100);
    run(7);
    rd(4'd0, v); check("R3 tick counts 7", v, 64'd107);
    repeat (3) @(negedge clk);
    rd(4'd0, v); check("R3 tick holds", v, 64'd107);
    wr(4'd2, 64'd1000);
    run(4);
    rd(4'd2, v); check("R3 sys tick counts 4", v, 64'd1004);
  endtask

  task automatic t_set_clr();
    logic [63:0] v;
    wr(4'd6, 64'h12);
    rd(4'd5, v); check("R4 set alias", v, 64'h12);
    check("R4 soft_irq high", {63'd0, soft_irq}, 64'd1);
    wr(4'd6, 64'h1);
    rd(4'd5, v); check("R4 set alias ORs", v, 64'h13);
    wr(4'd7, 64'h2);
    rd(4'd5, v); check("R5 clear alias", v, 64'h11);
    wr(4'd7, 64'h11);
    rd(4'd5, v); check("R5 clear to zero", v, 64'h0);
    check("R4 soft_irq low", {63'd0, soft_irq}, 64'd0);
    rd(4'd6, v); check("R1 alias reads zero", v, 64'h0);
  endtask

  task automatic t_tick_match();
    logic [63:0] v;
    wr(4'd1, 64'd20);
    wr(4'd0, 64'd18);
    run(2);
    rd(4'd5, v); check("R7 before match", v, 64'h0);
    run(1);
    rd(4'd5, v); check("R7 match sets bit0", v, 64'h1);
    rd(4'd0, v); check("R7 tick after match", v, 64'd21);
    wr(4'd7, 64'h1);
    run(30);
    rd(4'd5, v); check("R7 single hit per pass", v, 64'h0);
  endtask

  task automatic t_direct_race();
    logic [63:0] v;
    wr(4'd5, 64'h1_2345);
    rd(4'd5, v); check("R6 direct replaces", v, 64'h1_2345);
    wr(4'd7, 64'h1_FFFF);
    wr(4'd1, 64'd50);
    wr(4'd0, 64'd50);
    @(negedge clk);
    count_en = 1'b1; wr_en = 1'b1; reg_idx = 4'd5; wr_data = 64'h4;
    @(negedge clk);
    count_en = 1'b0; wr_en = 1'b0;
    rd(4'd5, v); check("R6 write ORed with match", v, 64'h5);
    wr(4'd7, 64'h1_FFFF);
  endtask

  task automatic t_sys_matches();
    logic [63:0] v;
    wr(4'd4, 64'd300);
    wr(4'd2, 64'd298);
    run(2);
    check("R9 hyp before match", {63'd0, hyp_irq}, 64'd0);
    run(1);
    check("R9 hyp_irq", {63'd0, hyp_irq}, 64'd1);
    rd(4'd8, v); check("R9 pending reads 1", v, 64'd1);
    rd(4'd5, v); check("R9 softint untouched", v, 64'd0);
    wr(4'd8, 64'd0);
    wr(4'd3, 64'd500);
    wr(4'd2, 64'd499);
    run(2);
    rd(4'd5, v); check("R8 sys match sets bit16", v, 64'h1_0000);
    check("R8 soft_irq", {63'd0, soft_irq}, 64'd1);
    wr(4'd7, 64'h1_FFFF);
  endtask

  task automatic t_disable();
    logic [63:0] v;
    wr(4'd1, DIS | 64'd600);
    wr(4'd0, 64'd598);
    run(4);
    rd(4'd5, v); check("R10 disabled compare silent", v, 64'h0);
    wr(4'd1, 64'd700);
    wr(4'd0, 64'd690);
    run(3);
    wr(4'd1, DIS | 64'd700);
    run(15);
    rd(4'd5, v); check("R10 cancel pending match", v, 64'h0);
    rd(4'd0, v); check("R10 counter passed target", v, 64'd708);
  endtask

  task automatic t_recheck();
    wr(4'd9, 64'h2);
    check("R11 enable rise pulses", {63'd0, recheck}, 64'd1);
    @(negedge clk);
    check("R11 pulse one cycle", {63'd0, recheck}, 64'd0);
    wr(4'd9, 64'h2);
    check("R11 enable already on", {63'd0, recheck}, 64'd0);
    wr(4'd10, 64'd5);
    check("R11 level raised", {63'd0, recheck}, 64'd0);
    wr(4'd10, 64'd3);
    check("R11 level lowered", {63'd0, recheck}, 64'd1);
    wr(4'd10, 64'd3);
    check("R11 level equal", {63'd0, recheck}, 64'd0);
    wr(4'd13, 64'hABC);
    check("R11 queue write", {63'd0, recheck}, 64'd1);
  endtask

  task automatic t_version();
    logic [63:0] v;
    rd(4'd11, v); check("R12 version read", v, VER);
    wr(4'd11, 64'd123);
    check("R12 illegal flagged", {63'd0, illegal_wr}, 64'd1);
    rd(4'd11, v); check("R12 version unchanged", v, VER);
    @(negedge clk);
    check("R12 flag one cycle", {63'd0, illegal_wr}, 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_counters();
    t_set_clr();
    t_tick_match();
    t_direct_race();
    t_sys_matches();
    t_disable();
    t_recheck();
    t_version();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule